// File: doc/BRIEF.md
# Supervisor Trap and Delegation Unit

This unit keeps the hart's current privilege level (machine or supervisor) together with every control register that trap handling needs at both levels: status, exception PC, cause, trap value and trap vector. It also holds the per-cause exception delegation mask and the address-translation control word. The pipeline hands it a trap request (cause, faulting PC, trap value, interrupt flag) or a return request (mret, sret). The unit decides which level takes the event, commits every register change that belongs to the event on one clock edge, and drives the redirect PC in the same cycle as the request.

Ordinary CSR reads are combinational on `csr_addr`. Writes take effect on the next edge. Only one physical status register exists, and the supervisor status view is a masked window onto it. Only direct (non-vectored) trap vectors exist. Interrupts are always handled at machine level.

Top module: `priv_trap_unit`

## Requirements
- R1: After reset the privilege is machine (`priv_mode` = 2'b11), and status, delegation mask and translation control all read 0. `priv_upd` is low.
- R2: A read of supervisor status (address 0x100) returns machine status (0x300) ANDed with 0x000C0122. That mask covers SIE bit 1, SPIE bit 5, SPP bit 8, and bits 18 and 19. Machine status keeps only the bits in 0x000C19AA, which adds MIE bit 3, MPIE bit 7 and MPP bits 12:11.
- R3: A write to supervisor status changes only the bits inside 0x000C0122. Every other machine status bit keeps its value.
- R4: An exception is delegated only when three conditions hold: the current privilege is supervisor, the request is not an interrupt, and bit `trap_cause` of the delegation mask (0x302) is set. Any other trap is handled at machine level and leaves the supervisor CSRs untouched.
- R5: A delegated trap writes sepc (0x141), scause (0x142) and stval (0x143). It redirects to stvec (0x105) and sets the privilege to supervisor. A supervisor environment call uses cause 9.
- R6: A trap that is not delegated writes mepc (0x341), mcause (0x342) and mtval (0x343). It redirects to mtvec (0x305) and sets the privilege to machine.
- R7: A supervisor-handled trap sets SPP to 1 when the previous privilege was supervisor. It copies SIE into SPIE and clears SIE.
- R8: A machine-handled trap loads MPP with the previous privilege, copies MIE into MPIE and clears MIE.
- R9: mret redirects to mepc. It sets the privilege to supervisor when MPP is 01 and to machine otherwise. It copies MPIE into MIE and sets MPIE.
- R10: sret redirects to sepc and sets the privilege to supervisor. It copies SPIE into SIE, sets SPIE and clears SPP.
- R11: An interrupt is never delegated, whatever the mask holds. Its mcause has bit 31 set above the cause code.
- R12: `redir_valid` and `redir_pc` are valid in the request cycle. CSR and privilege effects show on the next cycle. `priv_upd` is a one-cycle pulse in the cycle after each trap or return.
- R13: Writes to both trap vectors force bits 1:0 to 0. The translation control word (0x180) holds all 32 bits and drives `satp_q`.
- R14: Requests are served in priority order: trap first, then mret, then sret. A CSR write in the same cycle as any of these is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap request strobe |
| trap_irq | input | 1 | Request is an interrupt |
| trap_cause | input | 5 | Exception or interrupt code |
| trap_pc | input | 32 | PC of the trapping instruction |
| trap_val | input | 32 | Trap value (faulting address or 0) |
| mret_req | input | 1 | Machine return strobe |
| sret_req | input | 1 | Supervisor return strobe |
| csr_wr | input | 1 | CSR write enable |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data, combinational |
| redir_valid | output | 1 | Redirect this cycle |
| redir_pc | output | 32 | Redirect target |
| priv_mode | output | 2 | Current privilege (01 supervisor, 11 machine) |
| priv_upd | output | 1 | Pulse after a trap or return commits |
| satp_q | output | 32 | Address-translation control word |

## Verification
The redirect target is due in the same cycle as the request, so the bench samples it one time unit after it drives the request. Privilege, `priv_upd` and every committed CSR are due one edge later. The bench samples them just after the following falling edge and reads `priv_upd` once more a cycle after that to confirm it has fallen. CSR reads are combinational, and the bench also reads mepc inside a request cycle to confirm that it still shows the old value. Each check is queued by the driver with its expected value, and the monitor compares it at the sample point.

// File: rtl/priv_trap_pkg.sv
// Shared constants for the trap unit: CSR addresses, status bit positions,
// the masks that define the two status views, and privilege encodings.
// Assumes a 32-bit hart with machine and supervisor levels only.
package priv_trap_pkg;
    localparam int XLEN    = 32;
    localparam int CAUSE_W = $clog2(XLEN);

    typedef enum logic [1:0] {
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    // Base of each level's trap CSR block; offsets below are shared
    localparam logic [11:0] BASE_M = 12'h300;
    localparam logic [11:0] BASE_S = 12'h100;
    localparam logic [11:0] OFS_STATUS = 12'h000;
    localparam logic [11:0] OFS_DELEG  = 12'h002;
    localparam logic [11:0] OFS_TVEC   = 12'h005;
    localparam logic [11:0] OFS_EPC    = 12'h041;
    localparam logic [11:0] OFS_CAUSE  = 12'h042;
    localparam logic [11:0] OFS_TVAL   = 12'h043;
    localparam logic [11:0] ADDR_XLATE = 12'h180;

    // Status bit positions
    localparam int B_SIE  = 1;
    localparam int B_MIE  = 3;
    localparam int B_SPIE = 5;
    localparam int B_MPIE = 7;
    localparam int B_SPP  = 8;
    localparam int B_MPP  = 11;
    localparam int B_SUM  = 18;
    localparam int B_MXR  = 19;

    localparam logic [XLEN-1:0] S_VIEW_MASK =
        (32'd1 << B_SIE) | (32'd1 << B_SPIE) | (32'd1 << B_SPP) |
        (32'd1 << B_SUM) | (32'd1 << B_MXR);
    localparam logic [XLEN-1:0] M_KEEP_MASK =
        S_VIEW_MASK | (32'd1 << B_MIE) | (32'd1 << B_MPIE) | (32'd3 << B_MPP);
endpackage

// File: rtl/trap_router.sv
// Decides the handling level of a trap and resolves the event priority
// (trap, then mret, then sret). Produces the one-hot commit events, the
// redirect target and the next privilege. Purely combinational; assumes
// at most one event is consumed per cycle.
module trap_router
    import priv_trap_pkg::*;
(
    input  logic               trap_req,
    input  logic               trap_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic               mret_req,
    input  logic               sret_req,
    input  logic [1:0]         priv_q,
    input  logic [XLEN-1:0]    deleg_q,
    input  logic [1:0]         mpp_q,
    input  logic [XLEN-1:0]    epc_m,
    input  logic [XLEN-1:0]    epc_s,
    input  logic [XLEN-1:0]    tvec_m,
    input  logic [XLEN-1:0]    tvec_s,
    output logic               ev_trap_m,
    output logic               ev_trap_s,
    output logic               ev_mret,
    output logic               ev_sret,
    output logic               redir_valid,
    output logic [XLEN-1:0]    redir_pc,
    output logic [1:0]         next_priv
);
    logic to_s;

    // Per-cause delegation decision: exceptions from supervisor only
    always_comb begin
        to_s = (priv_q != PRIV_M) && !trap_irq && deleg_q[trap_cause];
    end

    // Event priority and one-hot event strobes
    always_comb begin
        ev_trap_s = trap_req && to_s;
        ev_trap_m = trap_req && !to_s;
        ev_mret   = !trap_req && mret_req;
        ev_sret   = !trap_req && !mret_req && sret_req;
    end

    // Redirect target and privilege after the event
    always_comb begin
        redir_valid = ev_trap_m || ev_trap_s || ev_mret || ev_sret;
        redir_pc    = '0;
        next_priv   = priv_q;
        if (ev_trap_m) begin
            redir_pc  = tvec_m;
            next_priv = PRIV_M;
        end else if (ev_trap_s) begin
            redir_pc  = tvec_s;
            next_priv = PRIV_S;
        end else if (ev_mret) begin
            redir_pc  = epc_m;
            next_priv = (mpp_q == PRIV_S) ? PRIV_S : PRIV_M;
        end else if (ev_sret) begin
            redir_pc  = epc_s;
            next_priv = PRIV_S;
        end
    end

    // R14: at most one event is committed in any cycle
    always_comb begin
        one_event_chk: assert ($onehot0({ev_trap_m, ev_trap_s, ev_mret, ev_sret}));
    end
endmodule

// File: rtl/status_ctl.sv
// Holds the single physical status register. Applies trap-entry and return
// updates to the interrupt-enable stack and the previous-privilege fields,
// and serves writes through both the full and the masked supervisor view.
// Assumes the caller blocks CSR writes in cycles that carry an event.
module status_ctl
    import priv_trap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_trap_m,
    input  logic            ev_trap_s,
    input  logic            ev_mret,
    input  logic            ev_sret,
    input  logic [1:0]      prev_priv,
    input  logic            wr_full,
    input  logic            wr_sview,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] status_q
);
    logic [XLEN-1:0] status_d;

    // Next status value for the event or write of this cycle
    always_comb begin
        status_d = status_q;
        if (ev_trap_m) begin
            status_d[B_MPP+1:B_MPP] = prev_priv;
            status_d[B_MPIE]        = status_q[B_MIE];
            status_d[B_MIE]         = 1'b0;
        end else if (ev_trap_s) begin
            status_d[B_SPP]  = (prev_priv == PRIV_S);
            status_d[B_SPIE] = status_q[B_SIE];
            status_d[B_SIE]  = 1'b0;
        end else if (ev_mret) begin
            status_d[B_MIE]  = status_q[B_MPIE];
            status_d[B_MPIE] = 1'b1;
        end else if (ev_sret) begin
            status_d[B_SIE]  = status_q[B_SPIE];
            status_d[B_SPIE] = 1'b1;
            status_d[B_SPP]  = 1'b0;
        end else if (wr_full) begin
            status_d = wdata & M_KEEP_MASK;
        end else if (wr_sview) begin
            status_d = (status_q & ~S_VIEW_MASK) | (wdata & S_VIEW_MASK);
        end
    end

    // Status register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // R3
    sview_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sview && !wr_full && !ev_trap_m && !ev_trap_s && !ev_mret && !ev_sret
        |=> (status_q & ~S_VIEW_MASK) == ($past(status_q) & ~S_VIEW_MASK));
    // R7
    strap_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_trap_s |=> !status_q[B_SIE] && status_q[B_SPIE] == $past(status_q[B_SIE]));
    // R8
    mtrap_pp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_trap_m |=> status_q[B_MPP+1:B_MPP] == $past(prev_priv) && !status_q[B_MIE]);
    // R9
    mret_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mret |=> status_q[B_MIE] == $past(status_q[B_MPIE]) && status_q[B_MPIE]);
endmodule

// File: rtl/lvl_trap_csrs.sv
// One level's trap CSR block: exception PC, cause, trap value and trap vector.
// A trap commit loads PC, cause and value together; software writes reach
// any of the four. Assumes write and commit never occur in the same cycle.
module lvl_trap_csrs
    import priv_trap_pkg::*;
#(
    parameter logic [11:0] LVL_BASE = 12'h300
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [XLEN-1:0] commit_epc,
    input  logic [XLEN-1:0] commit_cause,
    input  logic [XLEN-1:0] commit_tval,
    input  logic            csr_wr,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] tvec_q,
    output logic            rd_hit,
    output logic [XLEN-1:0] rd_data
);
    localparam logic [11:0] A_TVEC  = LVL_BASE + OFS_TVEC;
    localparam logic [11:0] A_EPC   = LVL_BASE + OFS_EPC;
    localparam logic [11:0] A_CAUSE = LVL_BASE + OFS_CAUSE;
    localparam logic [11:0] A_TVAL  = LVL_BASE + OFS_TVAL;

    logic [XLEN-1:0] cause_q;
    logic [XLEN-1:0] tval_q;

    // Trap commit or software write of the four registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
            tval_q  <= '0;
            tvec_q  <= '0;
        end else if (commit) begin
            epc_q   <= commit_epc;
            cause_q <= commit_cause;
            tval_q  <= commit_tval;
        end else if (csr_wr) begin
            case (csr_addr)
                A_EPC:   epc_q   <= csr_wdata;
                A_CAUSE: cause_q <= csr_wdata;
                A_TVAL:  tval_q  <= csr_wdata;
                A_TVEC:  tvec_q  <= {csr_wdata[XLEN-1:2], 2'b00};
                default: ;
            endcase
        end
    end

    // Read decode for this level's block
    always_comb begin
        rd_hit  = 1'b1;
        rd_data = '0;
        case (csr_addr)
            A_EPC:   rd_data = epc_q;
            A_CAUSE: rd_data = cause_q;
            A_TVAL:  rd_data = tval_q;
            A_TVEC:  rd_data = tvec_q;
            default: rd_hit = 1'b0;
        endcase
    end

    // R5 R6: a commit loads PC, cause and value together
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> epc_q == $past(commit_epc) && cause_q == $past(commit_cause)
                   && tval_q == $past(commit_tval));
    // R4: without commit or write the captured trap state holds
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit && !csr_wr |=> $stable(epc_q) && $stable(cause_q) && $stable(tval_q));
endmodule

// File: rtl/priv_trap_unit.sv
// Top of the supervisor trap and delegation unit. Keeps the privilege level,
// the delegation mask and the translation control word, instantiates the
// router, the status register and one trap CSR block per level, and
// multiplexes CSR reads. Assumes requests are single-cycle strobes.
module priv_trap_unit
    import priv_trap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_req,
    input  logic               trap_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_pc,
    input  logic [XLEN-1:0]    trap_val,
    input  logic               mret_req,
    input  logic               sret_req,
    input  logic               csr_wr,
    input  logic [11:0]        csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               redir_valid,
    output logic [XLEN-1:0]    redir_pc,
    output logic [1:0]         priv_mode,
    output logic               priv_upd,
    output logic [XLEN-1:0]    satp_q
);
    localparam int NLVL = 2;   // index 0 machine, 1 supervisor

    logic [1:0]      priv_q;
    logic [XLEN-1:0] deleg_q;
    logic [XLEN-1:0] status_q;
    logic            ev_trap_m, ev_trap_s, ev_mret, ev_sret;
    logic [1:0]      next_priv;
    logic            wr_ok;
    logic [XLEN-1:0] cause_word;
    logic [XLEN-1:0] epc_arr  [NLVL];
    logic [XLEN-1:0] tvec_arr [NLVL];
    logic            hit_arr  [NLVL];
    logic [XLEN-1:0] rdat_arr [NLVL];
    logic            commit_arr [NLVL];

    // CSR writes are dropped in any cycle that carries a trap or return
    always_comb begin
        wr_ok      = csr_wr && !(trap_req || mret_req || sret_req);
        cause_word = {trap_irq, {(XLEN-1-CAUSE_W){1'b0}}, trap_cause};
        commit_arr[0] = ev_trap_m;
        commit_arr[1] = ev_trap_s;
    end

    trap_router u_router (
        .trap_req    (trap_req),
        .trap_irq    (trap_irq),
        .trap_cause  (trap_cause),
        .mret_req    (mret_req),
        .sret_req    (sret_req),
        .priv_q      (priv_q),
        .deleg_q     (deleg_q),
        .mpp_q       (status_q[B_MPP+1:B_MPP]),
        .epc_m       (epc_arr[0]),
        .epc_s       (epc_arr[1]),
        .tvec_m      (tvec_arr[0]),
        .tvec_s      (tvec_arr[1]),
        .ev_trap_m   (ev_trap_m),
        .ev_trap_s   (ev_trap_s),
        .ev_mret     (ev_mret),
        .ev_sret     (ev_sret),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .next_priv   (next_priv)
    );

    status_ctl u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_trap_m (ev_trap_m),
        .ev_trap_s (ev_trap_s),
        .ev_mret   (ev_mret),
        .ev_sret   (ev_sret),
        .prev_priv (priv_q),
        .wr_full   (wr_ok && csr_addr == BASE_M + OFS_STATUS),
        .wr_sview  (wr_ok && csr_addr == BASE_S + OFS_STATUS),
        .wdata     (csr_wdata),
        .status_q  (status_q)
    );

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        lvl_trap_csrs #(
            .LVL_BASE ((g == 0) ? BASE_M : BASE_S)
        ) u_lvl (
            .clk          (clk),
            .rst_n        (rst_n),
            .commit       (commit_arr[g]),
            .commit_epc   (trap_pc),
            .commit_cause (cause_word),
            .commit_tval  (trap_val),
            .csr_wr       (wr_ok),
            .csr_addr     (csr_addr),
            .csr_wdata    (csr_wdata),
            .epc_q        (epc_arr[g]),
            .tvec_q       (tvec_arr[g]),
            .rd_hit       (hit_arr[g]),
            .rd_data      (rdat_arr[g])
        );
    end

    // Privilege, delegation mask, translation word and update pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q   <= PRIV_M;
            deleg_q  <= '0;
            satp_q   <= '0;
            priv_upd <= 1'b0;
        end else begin
            priv_q   <= next_priv;
            priv_upd <= redir_valid;
            if (wr_ok && csr_addr == BASE_M + OFS_DELEG) deleg_q <= csr_wdata;
            if (wr_ok && csr_addr == ADDR_XLATE)          satp_q  <= csr_wdata;
        end
    end

    // CSR read multiplexer
    always_comb begin
        csr_rdata = '0;
        if (csr_addr == BASE_M + OFS_STATUS)      csr_rdata = status_q;
        else if (csr_addr == BASE_S + OFS_STATUS) csr_rdata = status_q & S_VIEW_MASK;
        else if (csr_addr == BASE_M + OFS_DELEG)  csr_rdata = deleg_q;
        else if (csr_addr == ADDR_XLATE)          csr_rdata = satp_q;
        else begin
            for (int i = 0; i < NLVL; i++) begin
                if (hit_arr[i]) csr_rdata = rdat_arr[i];
            end
        end
    end

    assign priv_mode = priv_q;

    // R4
    mpriv_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req && priv_mode == PRIV_M |=> priv_mode == PRIV_M);
    // R11
    irq_to_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req && trap_irq |=> priv_mode == PRIV_M);
    // R10
    sret_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sret_req && !trap_req && !mret_req |=> priv_mode == PRIV_S);
    // R12
    upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_upd |-> $past(trap_req || mret_req || sret_req));
    // R1
    reset_priv_chk: assert property (@(posedge clk)
        !rst_n |=> priv_mode == PRIV_M && !priv_upd);
endmodule

// File: tb/priv_trap_unit_bench.sv
// Scoreboard bench: driver tasks queue expected items, a monitor pops and
// compares them at the sample point the driver announces.
module priv_trap_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 0, trap_irq = 0, mret_req = 0, sret_req = 0, csr_wr = 0;
    logic [4:0]  trap_cause = '0;
    logic [31:0] trap_pc = '0, trap_val = '0, csr_wdata = '0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_rdata, redir_pc, satp_q;
    logic        redir_valid, priv_upd;
    logic [1:0]  priv_mode;

    always #5 clk = ~clk;

    priv_trap_unit u_priv_trap_unit (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_irq(trap_irq),
        .trap_cause(trap_cause), .trap_pc(trap_pc), .trap_val(trap_val),
        .mret_req(mret_req), .sret_req(sret_req), .csr_wr(csr_wr),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .priv_mode(priv_mode),
        .priv_upd(priv_upd), .satp_q(satp_q)
    );

    typedef enum int {K_RD, K_PC, K_PRIV, K_UPD, K_SATP, K_RV} kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t  sb_q[$];
    event   sample_ev;
    int     checks = 0;
    int     failures = 0;
    bit     done = 0;
    item_t  it;
    logic [31:0] act;

    // Monitor: compare every queued item against the live outputs
    always @(sample_ev) begin
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.kind)
                K_RD:    act = csr_rdata;
                K_PC:    act = redir_valid ? redir_pc : 32'hBAD0BAD0;
                K_PRIV:  act = {30'd0, priv_mode};
                K_UPD:   act = {31'd0, priv_upd};
                K_SATP:  act = satp_q;
                default: act = {31'd0, redir_valid};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_item(kind_e k, logic [31:0] e, string tag);
        item_t n;
        n.kind = k; n.exp = e; n.tag = tag;
        #1;
        sb_q.push_back(n);
        -> sample_ev;
        #1;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
        csr_addr = a;
        expect_item(K_RD, e, tag);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        csr_addr = a; csr_wdata = d; csr_wr = 1;
        step();
        csr_wr = 0;
    endtask

    task automatic do_trap(bit irq, logic [4:0] c, logic [31:0] pc, logic [31:0] v,
                           logic [31:0] exp_pc, string tag);
        trap_req = 1; trap_irq = irq; trap_cause = c; trap_pc = pc; trap_val = v;
        expect_item(K_PC, exp_pc, tag);
        step();
        trap_req = 0; trap_irq = 0;
    endtask

    task automatic do_ret(bit is_m, logic [31:0] exp_pc, string tag);
        if (is_m) mret_req = 1; else sret_req = 1;
        expect_item(K_PC, exp_pc, tag);
        step();
        mret_req = 0; sret_req = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    // Driver
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        expect_item(K_PRIV, 32'h3, "R1 priv after reset");
        expect_item(K_UPD, 32'h0, "R1 upd after reset");
        rd(12'h300, 32'h0, "R1 status after reset");
        rd(12'h302, 32'h0, "R1 deleg after reset");
        expect_item(K_SATP, 32'h0, "R1 satp after reset");

        // R2 R3 status views
        wr(12'h300, 32'hFFFF_FFFF);
        rd(12'h300, 32'h000C_19AA, "R2 mstatus keep mask");
        wr(12'h100, 32'h0);
        rd(12'h300, 32'h0000_1888, "R3 sview write keeps other bits");
        rd(12'h100, 32'h0, "R2 sview read cleared");
        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h100, 32'h000C_0122, "R2 sview read mask");
        rd(12'h300, 32'h000C_19AA, "R3 sview set only masked");
        wr(12'h300, 32'h0000_0808);

        // R13 vectors and translation word
        wr(12'h305, 32'h0000_1003);
        rd(12'h305, 32'h0000_1000, "R13 mtvec low bits");
        wr(12'h105, 32'h0000_2001);
        rd(12'h105, 32'h0000_2000, "R13 stvec low bits");
        wr(12'h180, 32'h8000_5000);
        rd(12'h180, 32'h8000_5000, "R13 satp read");
        expect_item(K_SATP, 32'h8000_5000, "R13 satp port");

        // R9 mret to supervisor
        wr(12'h341, 32'h0040_0000);
        do_ret(1, 32'h0040_0000, "R9 R12 mret redirect");
        expect_item(K_PRIV, 32'h1, "R9 mret priv S");
        expect_item(K_UPD, 32'h1, "R12 upd pulse high");
        rd(12'h300, 32'h0000_0880, "R9 mret MIE MPIE");
        @(negedge clk);
        expect_item(K_UPD, 32'h0, "R12 upd pulse low");

        // R5 R7 delegated supervisor ecall
        wr(12'h302, 32'h0000_0200);
        wr(12'h100, 32'h0000_0002);
        do_trap(0, 5'd9, 32'h0040_0010, 32'h0, 32'h0000_2000, "R5 deleg redirect stvec");
        expect_item(K_PRIV, 32'h1, "R5 priv S");
        rd(12'h141, 32'h0040_0010, "R5 sepc");
        rd(12'h142, 32'h0000_0009, "R5 scause ecall 9");
        rd(12'h143, 32'h0, "R5 stval");
        rd(12'h300, 32'h0000_09A0, "R7 SPP SPIE SIE");
        rd(12'h341, 32'h0040_0000, "R4 mepc untouched by delegated trap");
        rd(12'h342, 32'h0, "R4 mcause untouched by delegated trap");

        // R10 sret
        do_ret(0, 32'h0040_0010, "R10 sret redirect");
        expect_item(K_PRIV, 32'h1, "R10 sret priv S");
        rd(12'h300, 32'h0000_08A2, "R10 sret SIE SPIE SPP");

        // R6 R8 undelegated trap from S, mepc read old in request cycle
        wr(12'h302, 32'h0);
        csr_addr = 12'h341;
        trap_req = 1; trap_cause = 5'd9; trap_pc = 32'h0040_0020; trap_val = 32'h55;
        expect_item(K_RD, 32'h0040_0000, "R12 mepc old in request cycle");
        expect_item(K_PC, 32'h0000_1000, "R6 redirect mtvec");
        step();
        trap_req = 0;
        expect_item(K_PRIV, 32'h3, "R6 priv M");
        rd(12'h341, 32'h0040_0020, "R6 mepc");
        rd(12'h342, 32'h0000_0009, "R6 mcause");
        rd(12'h343, 32'h0000_0055, "R6 mtval");
        rd(12'h300, 32'h0000_0822, "R8 MPP S MPIE MIE");
        rd(12'h141, 32'h0040_0010, "R4 sepc untouched");

        // R4 trap from M with mask set stays in M
        wr(12'h302, 32'h0000_0200);
        do_trap(0, 5'd9, 32'h0000_0100, 32'h0, 32'h0000_1000, "R4 M trap not delegated");
        expect_item(K_PRIV, 32'h3, "R4 priv stays M");
        rd(12'h341, 32'h0000_0100, "R4 mepc from M trap");
        rd(12'h300, 32'h0000_1822, "R8 MPP machine");

        // R9 mret with MPP=11 stays M
        do_ret(1, 32'h0000_0100, "R9 mret redirect M");
        expect_item(K_PRIV, 32'h3, "R9 mret priv M");
        rd(12'h300, 32'h0000_18A2, "R9 mret MPIE set");

        // back to S with MPIE=1
        wr(12'h300, 32'h0000_08A2);
        wr(12'h341, 32'h0000_0300);
        do_ret(1, 32'h0000_0300, "R9 mret to S again");
        expect_item(K_PRIV, 32'h1, "R9 priv S again");
        rd(12'h300, 32'h0000_08AA, "R9 MIE from MPIE");

        // R11 interrupt never delegated
        wr(12'h302, 32'hFFFF_FFFF);
        do_trap(1, 5'd5, 32'h0000_0400, 32'h0, 32'h0000_1000, "R11 irq redirect mtvec");
        expect_item(K_PRIV, 32'h3, "R11 irq priv M");
        rd(12'h342, 32'h8000_0005, "R11 mcause irq bit");
        rd(12'h341, 32'h0000_0400, "R11 mepc");
        rd(12'h300, 32'h0000_08A2, "R8 MPIE from MIE");

        // R14 trap beats mret and a same-cycle CSR write
        trap_req = 1; trap_cause = 5'd2; trap_pc = 32'h0000_0500; trap_val = 32'h77;
        mret_req = 1; csr_wr = 1; csr_addr = 12'h343; csr_wdata = 32'hDEAD;
        expect_item(K_PC, 32'h0000_1000, "R14 trap wins redirect");
        step();
        trap_req = 0; mret_req = 0; csr_wr = 0;
        expect_item(K_PRIV, 32'h3, "R14 priv M");
        rd(12'h343, 32'h0000_0077, "R14 write dropped mtval");
        rd(12'h341, 32'h0000_0500, "R14 mepc");
        rd(12'h342, 32'h0000_0002, "R14 mcause");
        rd(12'h300, 32'h0000_1822, "R14 status from trap");
        expect_item(K_RV, 32'h0, "R12 no redirect when idle");

        done = 1;
        finish_run();
    end
endmodule